// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the control front end of a flow-through synchronous burst SRAM, built together with a small behavioural byte-lane memory array. Two active-low address strobes start accesses. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the byte write enables. Three chip enables decide whether a strobe starts an access or parks the device in a deselected state. After an access starts, a 2-bit burst counter moves through four consecutive words. Each cycle, an active-low step input either advances the counter or holds it, which gives a wait state.

The burst order is set by a static select input. In linear order the low address bits count upward and wrap within the aligned group of four. In interleaved order the low bits are the loaded value XOR the count. Read data is looked up combinationally from the registered address, so it is valid in the cycle right after the address is registered. The data bus is split into separate input and output vectors. An output-enable flag stands for the tri-state driver and is low during write cycles and while deselected. A write cycle commits the input data at the next rising edge, and only into the byte lanes whose enable was low.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is asserted, and after reset with no strobe applied, `dout_en` is 0.
- R2: A low `proc_stb_n` sampled with `cs_main_n` low, `cs_hi` high and `cs_lo_n` high-inactive (low) registers `addr` and starts a read. In the following cycle `dout_en` is 1 and `dout` shows the word at `addr`.
- R3: A low `proc_stb_n` has no effect while `cs_main_n` is high. A burst in progress keeps its address and keeps driving read data.
- R4: A low `ctrl_stb_n` with `cs_main_n` low (and the other two enables active) registers `addr`. The access is a write if any `byte_wr_n` bit is low at that edge, and a read otherwise.
- R5: A low `ctrl_stb_n` sampled while `cs_main_n` is high deselects the device: `dout_en` is 0 from the next cycle, and step pulses do not re-enable it.
- R6: A strobe that would start an access while `cs_hi` is low or `cs_lo_n` is high deselects the device instead (`dout_en` 0 next cycle).
- R7: During an access, `step_n` low at an edge moves to the next burst address, and `step_n` high holds the address (wait state).
- R8: With `order_sel` = 0 (linear), the low 2 address bits equal (loaded low bits + step count) mod 4. The upper bits never change within a burst.
- R9: With `order_sel` = 1 (interleaved), the low 2 address bits equal loaded low bits XOR step count.
- R10: A write cycle stores `din` at the following rising edge, only into the byte lanes whose `byte_wr_n` bit was low when the cycle was set up. Lane i is `din[8i+7:8i]`.
- R11: `dout_en` is 0 in every write cycle.
- R12: After a processor-strobe read, an edge with `step_n` high and any `byte_wr_n` bit low turns the next cycle into a write to the same loaded address.
- R13: If both strobes are low with `cs_main_n` low, the processor strobe wins, and the access is a read whatever `byte_wr_n` shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_stb_n | input | 1 | Processor-side address strobe, active low, read only |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low, read or write |
| step_n | input | 1 | Burst advance, active low; high inserts a wait state |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| cs_main_n | input | 1 | Primary chip enable, active low |
| cs_hi | input | 1 | Secondary chip enable, active high |
| cs_lo_n | input | 1 | Secondary chip enable, active low |
| addr | input | ADDR_W (6) | External word address |
| byte_wr_n | input | LANES (4) | Per-lane write enables, active low |
| din | input | LANES*LANE_W (32) | Write data, byte lanes a..d from bit 0 upward |
| dout | output | LANES*LANE_W (32) | Read data of the current burst address |
| dout_en | output | 1 | Output-driver enable (1 = bus driven with read data) |

## Verification
The hardest case to reach is a write reached through a processor-strobe start (R12). The bench first loads a read through the processor strobe. On the next edge it holds `step_n` high and lowers the byte enables. It then supplies data one edge later and reads the same address back. Partial-lane writes use a controller-strobe write with alternating lane enables over a word that was previously fully written, so every unwritten lane must keep its old byte. Interleaved order is checked from an odd base address, where the linear and interleaved sequences differ.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   typedef struct packed {
      logic load;      // register a new external address
      logic desel;     // drop into the deselected state
      logic load_wr;   // the loaded access is a write
   } strobe_dec_t;

endpackage

// File: rtl/sbs_strobe_arb.sv
module sbs_strobe_arb
   import sbs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             proc_stb_n,
   input  logic             ctrl_stb_n,
   input  logic             cs_main_n,
   input  logic             cs_hi,
   input  logic             cs_lo_n,
   input  logic [LANES-1:0] byte_wr_n,
   output strobe_dec_t      dec
);

   logic proc_go;
   logic ctrl_go;
   logic sec_ok;
   logic any_lane;

   always_comb begin
      proc_go  = !proc_stb_n && !cs_main_n;
      ctrl_go  = !ctrl_stb_n && !proc_go;
      sec_ok   = cs_hi && !cs_lo_n;
      any_lane = !(&byte_wr_n);

      dec.load    = (proc_go || (ctrl_go && !cs_main_n)) && sec_ok;
      dec.desel   = (proc_go || ctrl_go) && !dec.load;
      dec.load_wr = !proc_go && any_lane;
   end

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
   import sbs_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  burst_order_e     order,
   input  logic [CNT_W-1:0] base_lo,
   output logic [CNT_W-1:0] addr_lo
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      unique case (order)
         ORD_LINEAR:     addr_lo = base_lo + cnt_q;
         ORD_INTERLEAVE: addr_lo = base_lo ^ cnt_q;
         default:        addr_lo = base_lo;
      endcase
   end

endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  wr_lane,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_lane[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[addr];
   end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int CNT_W  = 2,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              step_n,
   input  logic              order_sel,
   input  logic              cs_main_n,
   input  logic              cs_hi,
   input  logic              cs_lo_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  byte_wr_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (ADDR_W <= CNT_W) begin : g_bad_addr
      $error("ADDR_W must exceed CNT_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   strobe_dec_t       dec;
   logic              active_q;
   logic              wr_q;
   logic [LANES-1:0]  lane_n_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  lo_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic              ctr_step;
   logic [LANES-1:0]  wr_lane;
   logic [DATA_W-1:0] rd_word;

   sbs_strobe_arb #(.LANES(LANES)) i_arb (
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .cs_main_n  (cs_main_n),
      .cs_hi      (cs_hi),
      .cs_lo_n    (cs_lo_n),
      .byte_wr_n  (byte_wr_n),
      .dec        (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wr_q     <= 1'b0;
         lane_n_q <= '1;
         base_q   <= '0;
      end else if (dec.load) begin
         active_q <= 1'b1;
         wr_q     <= dec.load_wr;
         lane_n_q <= byte_wr_n;
         base_q   <= addr;
      end else if (dec.desel) begin
         active_q <= 1'b0;
         wr_q     <= 1'b0;
         lane_n_q <= '1;
      end else if (active_q) begin
         wr_q     <= !(&byte_wr_n);
         lane_n_q <= byte_wr_n;
      end
   end

   assign ctr_step = active_q && !step_n && !dec.load && !dec.desel;

   sbs_burst_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (dec.load),
      .step    (ctr_step),
      .order   (burst_order_e'(order_sel)),
      .base_lo (base_q[CNT_W-1:0]),
      .addr_lo (lo_addr)
   );

   assign cur_addr = {base_q[ADDR_W-1:CNT_W], lo_addr};
   assign wr_lane  = (active_q && wr_q) ? ~lane_n_q : '0;

   sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_mem (
      .clk     (clk),
      .wr_lane (wr_lane),
      .addr    (cur_addr),
      .wdata   (din),
      .rdata   (rd_word)
   );

   assign dout_en = active_q && !wr_q;
   assign dout    = rd_word;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 2,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              proc_stb_n,
   input logic              ctrl_stb_n,
   input logic              step_n,
   input logic              cs_main_n,
   input logic              cs_hi,
   input logic              cs_lo_n,
   input logic [LANES-1:0]  byte_wr_n,
   input logic              dout_en,
   input logic              active_q,
   input logic [ADDR_W-1:0] cur_addr
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!dout_en); // R1
      end
   end

   AST_PROC_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && !cs_main_n && cs_hi && !cs_lo_n) |=> dout_en); // R2

   AST_PROC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !proc_stb_n && ctrl_stb_n && cs_main_n && step_n)
      |=> ($stable(cur_addr) && active_q)); // R3

   AST_CTRL_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_stb_n && cs_main_n) |=> !dout_en); // R5

   AST_SEC_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (((!proc_stb_n && !cs_main_n) || !ctrl_stb_n) && (!cs_hi || cs_lo_n))
      |=> !dout_en); // R6

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && step_n && proc_stb_n && ctrl_stb_n) |=> $stable(cur_addr)); // R7

   AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !step_n && proc_stb_n && ctrl_stb_n)
      |=> (cur_addr != $past(cur_addr)
           && cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W]))); // R8

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_stb_n && proc_stb_n && !cs_main_n && cs_hi && !cs_lo_n && !(&byte_wr_n))
      |=> !dout_en); // R11

endmodule

bind sync_burst_sram sbs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) i_sbs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .proc_stb_n (proc_stb_n),
   .ctrl_stb_n (ctrl_stb_n),
   .step_n     (step_n),
   .cs_main_n  (cs_main_n),
   .cs_hi      (cs_hi),
   .cs_lo_n    (cs_lo_n),
   .byte_wr_n  (byte_wr_n),
   .dout_en    (dout_en),
   .active_q   (active_q),
   .cur_addr   (cur_addr)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        proc_stb_n, ctrl_stb_n, step_n, order_sel;
   logic        cs_main_n, cs_hi, cs_lo_n;
   logic [5:0]  addr;
   logic [3:0]  byte_wr_n;
   logic [31:0] din;
   logic [31:0] dout;
   logic        dout_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] mdl [64];
   bit          q_en   [$];
   bit          q_chk  [$];
   logic [31:0] q_data [$];
   string       q_req  [$];

   localparam logic [31:0] D0 = 32'h11A0_22B0;
   localparam logic [31:0] D1 = 32'h3C41_5D62;
   localparam logic [31:0] D2 = 32'h7E83_9FA4;
   localparam logic [31:0] D3 = 32'hC5D6_E7F8;
   localparam logic [31:0] WF = 32'hDEAD_BEEF;
   localparam logic [31:0] PP = 32'h1234_5678;

   always #5 clk = ~clk;

   sync_burst_sram i_sync_burst_sram (
      .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
      .step_n(step_n), .order_sel(order_sel), .cs_main_n(cs_main_n), .cs_hi(cs_hi),
      .cs_lo_n(cs_lo_n), .addr(addr), .byte_wr_n(byte_wr_n), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic idle();
      proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; step_n = 1'b1;
      cs_main_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
      addr = '0; byte_wr_n = 4'hF; din = '0;
   endtask

   // model write: lanes with a low enable take the new byte
   task automatic mwrite(input int a, input logic [3:0] wn, input logic [31:0] d);
      for (int i = 0; i < 4; i++)
         if (!wn[i]) mdl[a][i*8 +: 8] = d[i*8 +: 8];
   endtask

   // driver: apply current inputs at one edge, queue the expected result
   task automatic tick(input bit e, input bit c, input logic [31:0] d, input string r);
      @(posedge clk);
      q_en.push_back(e); q_chk.push_back(c); q_data.push_back(d); q_req.push_back(r);
      @(negedge clk);
      idle();
   endtask

   // monitor: compare between edges
   always @(negedge clk) begin
      if (q_en.size() > 0) begin
         automatic bit          e = q_en.pop_front();
         automatic bit          c = q_chk.pop_front();
         automatic logic [31:0] d = q_data.pop_front();
         automatic string       r = q_req.pop_front();
         n_cmp++;
         if (dout_en !== e || (c && dout !== d)) begin
            n_bad++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     r, dout_en, dout, e, c ? d : dout);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      order_sel = 1'b0;
      @(negedge clk);
      tick(0, 0, '0, "R1 in reset");
      tick(0, 0, '0, "R1 in reset");
      rst_n = 1'b1;
      tick(0, 0, '0, "R1 after reset");

      // linear phase: controller-strobe burst write to 8..11 (R4, R11, R10)
      ctrl_stb_n = 0; addr = 8; byte_wr_n = 4'h0;
      tick(0, 0, '0, "R4 write load");
      step_n = 0; byte_wr_n = 4'h0; din = D0; mwrite(8, 4'h0, D0);
      tick(0, 0, '0, "R11 write cycle");
      step_n = 0; byte_wr_n = 4'h0; din = D1; mwrite(9, 4'h0, D1);
      tick(0, 0, '0, "R11 write cycle");
      step_n = 0; byte_wr_n = 4'h0; din = D2; mwrite(10, 4'h0, D2);
      tick(0, 0, '0, "R11 write cycle");
      step_n = 0; din = D3; mwrite(11, 4'h0, D3);
      tick(1, 1, mdl[8], "R8 linear wrap to base");
      step_n = 0; tick(1, 1, mdl[9], "R7 step");
      step_n = 0; tick(1, 1, mdl[10], "R7 step");
      step_n = 0; tick(1, 1, mdl[11], "R8 linear");
      step_n = 0; tick(1, 1, mdl[8], "R8 linear wrap");
      tick(1, 1, mdl[8], "R7 wait state");

      // R3: processor strobe masked by primary enable
      proc_stb_n = 0; cs_main_n = 1; addr = 20;
      tick(1, 1, mdl[8], "R3 masked strobe");
      proc_stb_n = 0; cs_main_n = 1; addr = 20; step_n = 0;
      tick(1, 1, mdl[9], "R3 burst continues");

      // R13/R2: both strobes, enables low -> processor read
      proc_stb_n = 0; ctrl_stb_n = 0; byte_wr_n = 4'h0; addr = 10;
      tick(1, 1, mdl[10], "R13 processor wins");
      step_n = 0; tick(1, 1, mdl[11], "R8 linear from 10");
      step_n = 0; tick(1, 1, mdl[8], "R8 linear from 10");
      step_n = 0; tick(1, 1, mdl[9], "R8 linear from 10");

      // R12: write after processor read at the loaded address
      proc_stb_n = 0; addr = 12; byte_wr_n = 4'h0;
      tick(1, 0, '0, "R2 read load");
      byte_wr_n = 4'h0;
      tick(0, 0, '0, "R12 becomes write");
      din = WF; mwrite(12, 4'h0, WF);
      tick(1, 1, mdl[12], "R12 same address");

      // R10: partial lanes through controller-strobe write
      ctrl_stb_n = 0; addr = 12; byte_wr_n = 4'b1010;
      tick(0, 0, '0, "R4 partial write load");
      din = PP; mwrite(12, 4'b1010, PP);
      tick(1, 1, mdl[12], "R10 lane merge");

      // R4 read through controller strobe
      ctrl_stb_n = 0; addr = 11;
      tick(1, 1, mdl[11], "R4 controller read");

      // R5 deselect
      ctrl_stb_n = 0; cs_main_n = 1;
      tick(0, 0, '0, "R5 deselect");
      step_n = 0; tick(0, 0, '0, "R5 stays deselected");

      // R6 secondary enables
      proc_stb_n = 0; addr = 8; cs_hi = 0;
      tick(0, 0, '0, "R6 high enable low");
      ctrl_stb_n = 0; addr = 8;
      tick(1, 1, mdl[8], "R4 reload");
      ctrl_stb_n = 0; addr = 8; cs_lo_n = 1;
      tick(0, 0, '0, "R6 low enable high");

      // interleaved phase
      rst_n = 0; order_sel = 1'b1;
      tick(0, 0, '0, "R1 in reset");
      rst_n = 1;
      proc_stb_n = 0; addr = 9;
      tick(1, 1, mdl[9], "R9 load 9");
      step_n = 0; tick(1, 1, mdl[8], "R9 interleave");
      step_n = 0; tick(1, 1, mdl[11], "R9 interleave");
      step_n = 0; tick(1, 1, mdl[10], "R9 interleave");
      step_n = 0; tick(1, 1, mdl[9], "R9 wrap");
      proc_stb_n = 0; addr = 11;
      tick(1, 1, mdl[11], "R9 load 11");
      step_n = 0; tick(1, 1, mdl[10], "R9 interleave");
      step_n = 0; tick(1, 1, mdl[9], "R9 interleave");
      step_n = 0; tick(1, 1, mdl[8], "R9 interleave");

      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule